// File: doc/BRIEF.md
# Interrupt-Line to Message Vector Bridge

This block turns a bank of peripheral interrupt lines into message requests on a single valid/ready output. Each message carries the index of the line that raised it. Every line has a small configuration word of its own. The word holds an enable bit and a mode bit. The mode bit selects one of two behaviours:

- **Rising-edge mode.** Each rising edge of the line queues a message.
- **Level mode.** A high line sends one message and then waits. Software must write an acknowledge before that line can send again.

Software reaches the configuration words through a simple write/read register port. The port decodes three windows onto the same words:

- a plain window that replaces the whole word;
- a set window that ORs the write data into the word;
- a clear window that removes from the word the bits written as 1.

Several lines can be pending at the same time. The output stage then presents the lowest pending index first. It holds that index steady until the consumer accepts it.

Top module: `irq_msg_bridge`

## Requirements
- R1: The word for vector n sits at offset 0x8 + 4*n, for n from 0 to 60. In the plain window (address bits [11:10] = 00), a read returns the enable in bit 0 and the mode in bit 3, with every other bit 0. A read at an offset that maps to no vector returns 0. This covers offsets below 0x8, offsets that are not a multiple of 4, offsets above vector 60, and the unused window with bits [11:10] = 01.
- R2: A write in the plain window replaces both stored bits of the word with write-data bits 0 and 3.
- R3: A write in the set window (bits [11:10] = 10) sets the stored bits that are 1 in the write data and keeps the others.
- R4: A write in the clear window (bits [11:10] = 11) clears the stored bits that are 1 in the write data and keeps the others.
- R5: A vector whose enable bit is 0 never produces a message, whatever its line does.
- R6: In rising-edge mode (bit 3 = 0), each rising edge of an enabled line makes that vector pending. A line that stays high raises nothing more. Edges that arrive while the vector is already pending merge into that one message.
- R7: In level mode (bit 3 = 1), an enabled and armed vector whose line is high becomes pending and is disarmed. It raises no further message while disarmed, even if the line stays high.
- R8: Writing 1 to bit 2 through the plain or the set window is an acknowledge. The acknowledge re-arms the vector, and if the line is high the vector becomes pending one cycle later. Bit 2 always reads 0.
- R9: When several vectors are pending and the output is free, the lowest pending index is presented first.
- R10: Once `msg_valid` is high, `msg_vec` holds its value until a cycle with `msg_ready` high. In that cycle the message is consumed and that vector's pending flag clears.
- R11: After reset the following hold:
  - every word reads 0;
  - no message is presented;
  - level-mode vectors start armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| irq_src | input | NUM_VEC | Peripheral interrupt lines, one per vector, synchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address; bits [11:10] select the window |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| msg_valid | output | 1 | A message request is presented |
| msg_ready | input | 1 | The consumer accepts the presented message |
| msg_vec | output | IDX_W | Vector index carried by the message |

## Verification
The hardest case to reach from the ports is this one: a lower-index vector becomes pending while a higher-index message sits stalled at the output. It checks that the presented index does not jump, and that the lower index wins as soon as the stall ends. The stimulus gets there by holding `msg_ready` low for one step after raising a high-index line. A low-index line is raised in that same window.

A second awkward case is a level-mode acknowledge that arrives while the line is still high. The stimulus drives two acknowledges. The first comes with the line held high. The second comes with the line low, and the line is raised only afterwards. This separates re-arming from immediate re-firing.

// File: rtl/irqb_pkg.sv
package irqb_pkg;

  // Bit positions inside a configuration word; software depends on them.
  localparam int CFG_EN_BIT  = 0;
  localparam int CFG_ACK_BIT = 2;
  localparam int CFG_LVL_BIT = 3;

  // Byte offset of the first word and spacing between words.
  localparam int CFG_BASE   = 8;
  localparam int CFG_STRIDE = 4;

  // Window selected by the two top address bits.
  typedef enum logic [1:0] {
    RGN_PLAIN = 2'b00,
    RGN_HOLE  = 2'b01,
    RGN_SET   = 2'b10,
    RGN_CLR   = 2'b11
  } rgn_e;

endpackage

// File: rtl/irqb_regs.sv
module irqb_regs
  import irqb_pkg::*;
#(
  parameter int NUM_VEC = 61,
  parameter int IDX_W   = 6,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic [NUM_VEC-1:0] cfg_en,
  output logic [NUM_VEC-1:0] cfg_lvl,
  output logic [NUM_VEC-1:0] ack_pulse
);

  localparam int OFF_W = ADDR_W - 2;
  localparam int VF_W  = OFF_W - 2;

  rgn_e              rgn;
  logic [OFF_W-1:0]  off;
  logic [OFF_W-1:0]  rel;
  logic [VF_W-1:0]   vfull;
  logic [IDX_W-1:0]  vsel;
  logic              hit;
  logic              cfg_we;

  logic [NUM_VEC-1:0] en_q, en_d;
  logic [NUM_VEC-1:0] lvl_q, lvl_d;
  logic [NUM_VEC-1:0] ack_q, ack_d;

  // Address decode.
  assign rgn   = rgn_e'(reg_addr[ADDR_W-1 -: 2]);
  assign off   = reg_addr[OFF_W-1:0];
  assign rel   = off - OFF_W'(CFG_BASE);
  assign vfull = rel[OFF_W-1:2];
  assign vsel  = vfull[IDX_W-1:0];
  assign hit   = (off >= OFF_W'(CFG_BASE)) && (rel[1:0] == 2'b00) &&
                 (32'(vfull) < NUM_VEC);
  assign cfg_we = reg_wr && hit && (rgn != RGN_HOLE);

  // Next state of the stored bits and of the acknowledge pulse.
  always_comb begin
    en_d  = en_q;
    lvl_d = lvl_q;
    ack_d = '0;
    if (cfg_we) begin
      for (int n = 0; n < NUM_VEC; n++) begin
        if (32'(vfull) == n) begin
          unique case (rgn)
            RGN_PLAIN: begin
              en_d[n]  = reg_wdata[CFG_EN_BIT];
              lvl_d[n] = reg_wdata[CFG_LVL_BIT];
              ack_d[n] = reg_wdata[CFG_ACK_BIT];
            end
            RGN_SET: begin
              en_d[n]  = en_q[n]  | reg_wdata[CFG_EN_BIT];
              lvl_d[n] = lvl_q[n] | reg_wdata[CFG_LVL_BIT];
              ack_d[n] = reg_wdata[CFG_ACK_BIT];
            end
            RGN_CLR: begin
              en_d[n]  = en_q[n]  & ~reg_wdata[CFG_EN_BIT];
              lvl_d[n] = lvl_q[n] & ~reg_wdata[CFG_LVL_BIT];
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      lvl_q <= '0;
      ack_q <= '0;
    end else begin
      if (cfg_we) begin
        en_q  <= en_d;
        lvl_q <= lvl_d;
      end
      ack_q <= ack_d;
    end
  end

  // Read path: only the plain window returns data; bit 2 is never stored.
  always_comb begin
    reg_rdata = '0;
    if (hit && (rgn == RGN_PLAIN)) begin
      reg_rdata[CFG_EN_BIT]  = en_q[vsel];
      reg_rdata[CFG_LVL_BIT] = lvl_q[vsel];
    end
  end

  assign cfg_en    = en_q;
  assign cfg_lvl   = lvl_q;
  assign ack_pulse = ack_q;

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata[DATA_W-1:CFG_LVL_BIT+1], reg_wdata[1]};

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_q));  // R8

  AST_ACK_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr) |=> (ack_q == '0));  // R8

endmodule

// File: rtl/irqb_track.sv
module irqb_track (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic en,
  input  logic lvl,
  input  logic ack,
  input  logic take,
  output logic pend
);

  logic src_q;
  logic armed_q, armed_d;
  logic pend_q, pend_d;
  logic edge_ev;
  logic lvl_ev;
  logic set_ev;

  assign edge_ev = !lvl && src && !src_q;
  assign lvl_ev  = lvl && src && (armed_q || ack);
  assign set_ev  = en && (edge_ev || lvl_ev);

  always_comb begin
    pend_d = en && (set_ev || (pend_q && !take));
    if (!lvl) begin
      armed_d = 1'b1;
    end else if (en && lvl_ev) begin
      armed_d = 1'b0;
    end else if (ack) begin
      armed_d = 1'b1;
    end else begin
      armed_d = armed_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= 1'b0;
      armed_q <= 1'b1;
      pend_q  <= 1'b0;
    end else begin
      src_q   <= src;
      armed_q <= armed_d;
      pend_q  <= pend_d;
    end
  end

  assign pend = pend_q;

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> (!pend_q));  // R5

  AST_EDGE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl && src && src_q && !pend_q) |=> (!pend_q));  // R6

  AST_LVL_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl && !armed_q && !ack && !pend_q) |=> (!pend_q));  // R7

endmodule

// File: rtl/irqb_arb.sv
module irqb_arb #(
  parameter int NUM_VEC = 61,
  parameter int IDX_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] pend,
  input  logic               msg_ready,
  output logic               msg_valid,
  output logic [IDX_W-1:0]   msg_vec,
  output logic [NUM_VEC-1:0] take
);

  logic [IDX_W-1:0] prio_idx;
  logic             any_pend;
  logic             lock_q, lock_d;
  logic [IDX_W-1:0] lock_idx_q;
  logic             hs;

  // Lowest set index wins.
  always_comb begin
    prio_idx = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (pend[i]) prio_idx = IDX_W'(i);
    end
  end

  assign any_pend  = |pend;
  assign msg_valid = lock_q || any_pend;
  assign msg_vec   = lock_q ? lock_idx_q : prio_idx;
  assign hs        = msg_valid && msg_ready;
  assign take      = hs ? (NUM_VEC'(1) << msg_vec) : '0;
  assign lock_d    = msg_valid && !msg_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
    end else begin
      lock_q <= lock_d;
      if (lock_d) lock_idx_q <= msg_vec;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vec)));  // R10

  AST_ZERO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_q && pend[0]) |-> (msg_vec == '0));  // R9

  AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take));  // R10

  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (32'(msg_vec) < NUM_VEC));  // R9

endmodule

// File: rtl/irq_msg_bridge.sv
module irq_msg_bridge #(
  parameter int NUM_VEC = 61,
  parameter int IDX_W   = $clog2(NUM_VEC),
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] irq_src,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [IDX_W-1:0]   msg_vec
);

  logic rst_meta_q, rst_sync_q;
  logic rst_int_n;

  logic [NUM_VEC-1:0] cfg_en;
  logic [NUM_VEC-1:0] cfg_lvl;
  logic [NUM_VEC-1:0] ack_pulse;
  logic [NUM_VEC-1:0] pend;
  logic [NUM_VEC-1:0] take;

  // Reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_int_n = rst_sync_q;

  irqb_regs #(
    .NUM_VEC (NUM_VEC),
    .IDX_W   (IDX_W),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cfg_en    (cfg_en),
    .cfg_lvl   (cfg_lvl),
    .ack_pulse (ack_pulse)
  );

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
    irqb_track u_trk (
      .clk   (clk),
      .rst_n (rst_int_n),
      .src   (irq_src[g]),
      .en    (cfg_en[g]),
      .lvl   (cfg_lvl[g]),
      .ack   (ack_pulse[g]),
      .take  (take[g]),
      .pend  (pend[g])
    );
  end

  irqb_arb #(
    .NUM_VEC (NUM_VEC),
    .IDX_W   (IDX_W)
  ) u_arb (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .pend      (pend),
    .msg_ready (msg_ready),
    .msg_valid (msg_valid),
    .msg_vec   (msg_vec),
    .take      (take)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_int_n) |-> (!msg_valid));  // R11

endmodule

// File: tb/irq_msg_bridge_bench.sv
module irq_msg_bridge_bench;

  localparam int NUM_VEC = 61;
  localparam int IDX_W   = 6;

  localparam logic [2:0] OP_WR    = 3'd0;
  localparam logic [2:0] OP_RD    = 3'd1;
  localparam logic [2:0] OP_SRC   = 3'd2;
  localparam logic [2:0] OP_MSG   = 3'd3;
  localparam logic [2:0] OP_NOMSG = 3'd4;

  localparam int NSTEP = 46;
  // {requirement, op, address, data or expected value}
  localparam logic [50:0] TBL [NSTEP] = '{
    {4'd11, OP_RD,    12'h008, 32'h0},  // R11 reset word
    {4'd2,  OP_WR,    12'h008, 32'h1},  // R2 enable v0, edge mode
    {4'd1,  OP_RD,    12'h008, 32'h1},  // R1
    {4'd6,  OP_SRC,   12'd0,   32'h1},  // R6 rise on v0
    {4'd6,  OP_MSG,   12'h000, 32'd0},  // R6
    {4'd6,  OP_NOMSG, 12'h000, 32'h0},  // R6 steady high: nothing
    {4'd6,  OP_SRC,   12'd0,   32'h0},
    {4'd6,  OP_SRC,   12'd0,   32'h1},
    {4'd6,  OP_SRC,   12'd0,   32'h0},
    {4'd6,  OP_SRC,   12'd0,   32'h1},  // R6 second rise merges
    {4'd6,  OP_MSG,   12'h000, 32'd0},  // R6
    {4'd6,  OP_NOMSG, 12'h000, 32'h0},  // R6 only one message
    {4'd6,  OP_SRC,   12'd0,   32'h0},
    {4'd5,  OP_SRC,   12'd7,   32'h1},  // R5 v7 disabled
    {4'd5,  OP_NOMSG, 12'h000, 32'h0},  // R5
    {4'd3,  OP_WR,    12'h81C, 32'h9},  // R3 v5 enable + level
    {4'd3,  OP_RD,    12'h01C, 32'h9},  // R3
    {4'd7,  OP_SRC,   12'd5,   32'h1},  // R7
    {4'd7,  OP_MSG,   12'h000, 32'd5},  // R7
    {4'd7,  OP_NOMSG, 12'h000, 32'h0},  // R7 disarmed
    {4'd7,  OP_NOMSG, 12'h000, 32'h0},  // R7
    {4'd8,  OP_WR,    12'h81C, 32'h4},  // R8 ack, line high
    {4'd8,  OP_RD,    12'h01C, 32'h9},  // R8 bit 2 reads 0
    {4'd8,  OP_MSG,   12'h000, 32'd5},  // R8 refire
    {4'd8,  OP_SRC,   12'd5,   32'h0},
    {4'd8,  OP_WR,    12'h81C, 32'h4},  // R8 ack, line low
    {4'd8,  OP_NOMSG, 12'h000, 32'h0},  // R8
    {4'd8,  OP_SRC,   12'd5,   32'h1},
    {4'd8,  OP_MSG,   12'h000, 32'd5},  // R8 armed fires
    {4'd4,  OP_WR,    12'hC1C, 32'h8},  // R4 drop level bit
    {4'd4,  OP_RD,    12'h01C, 32'h1},  // R4 enable kept
    {4'd4,  OP_NOMSG, 12'h000, 32'h0},  // R4 edge mode, no edge
    {4'd2,  OP_WR,    12'h008, 32'h8},  // R2 replace word
    {4'd2,  OP_RD,    12'h008, 32'h8},  // R2
    {4'd3,  OP_WR,    12'h808, 32'h1},  // R3
    {4'd3,  OP_RD,    12'h008, 32'h9},  // R3 level kept
    {4'd1,  OP_RD,    12'h0FC, 32'h0},  // R1 past vector 60
    {4'd1,  OP_RD,    12'h004, 32'h0},  // R1 below base
    {4'd1,  OP_RD,    12'h41C, 32'h0},  // R1 unused window
    {4'd1,  OP_WR,    12'h0F8, 32'h1},  // R1 v60 enable
    {4'd1,  OP_WR,    12'h00C, 32'h1},  // R1 v1 enable
    {4'd10, OP_SRC,   12'd60,  32'h1},
    {4'd10, OP_SRC,   12'd1,   32'h1},  // R10 v60 stalls here
    {4'd10, OP_MSG,   12'h000, 32'd60}, // R10 held despite v1
    {4'd9,  OP_MSG,   12'h000, 32'd1},  // R9
    {4'd10, OP_NOMSG, 12'h000, 32'h0}   // R10 cleared
  };

  logic               clk;
  logic               rst_n;
  logic [NUM_VEC-1:0] irq_src;
  logic               reg_wr;
  logic [11:0]        reg_addr;
  logic [31:0]        reg_wdata;
  logic [31:0]        reg_rdata;
  logic               msg_valid;
  logic               msg_ready;
  logic [IDX_W-1:0]   msg_vec;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  irq_msg_bridge u_irq_msg_bridge (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_src   (irq_src),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_vec   (msg_vec)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input int req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL R%0d actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_step(input logic [3:0] req, input logic [2:0] op,
                         input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr    = 1'b0;
    msg_ready = 1'b0;
    case (op)
      OP_WR: begin
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
      end
      OP_RD: begin
        reg_addr = a;
        #1;
        check(reg_rdata == d, int'(req), reg_rdata, d);
      end
      OP_SRC: irq_src[a[5:0]] = d[0];
      OP_MSG: begin
        check(msg_valid && (msg_vec == d[5:0]), int'(req),
              {25'b0, msg_valid, msg_vec}, {25'b0, 1'b1, d[5:0]});
        msg_ready = 1'b1;
      end
      OP_NOMSG: check(!msg_valid, int'(req), {31'b0, msg_valid}, 32'h0);
      default: ;
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    irq_src   = '0;
    reg_wr    = 1'b0;
    reg_addr  = '0;
    reg_wdata = '0;
    msg_ready = 1'b0;
    repeat (3) @(negedge clk);
    check(!msg_valid, 11, {31'b0, msg_valid}, 32'h0);  // R11 during reset
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NSTEP; i++) begin
      do_step(TBL[i][50:47], TBL[i][46:44], TBL[i][43:32], TBL[i][31:0]);
    end

    // R9: three lines rise together, lowest index goes first.
    do_step(4'd9, OP_WR, 12'h010, 32'h1);
    do_step(4'd9, OP_WR, 12'h014, 32'h1);
    do_step(4'd9, OP_WR, 12'h0A8, 32'h1);
    @(negedge clk);
    reg_wr = 1'b0;
    irq_src[2]  = 1'b1;
    irq_src[3]  = 1'b1;
    irq_src[40] = 1'b1;
    do_step(4'd9, OP_MSG, 12'h000, 32'd2);
    do_step(4'd9, OP_MSG, 12'h000, 32'd3);
    do_step(4'd9, OP_MSG, 12'h000, 32'd40);
    do_step(4'd9, OP_NOMSG, 12'h000, 32'h0);

    // R11: reset mid-run clears words; level vectors start armed.
    @(negedge clk);
    rst_n    = 1'b0;
    reg_addr = 12'h0F8;
    #1;
    check(reg_rdata == 32'h0, 11, reg_rdata, 32'h0);
    check(!msg_valid, 11, {31'b0, msg_valid}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_step(4'd11, OP_RD, 12'h01C, 32'h0);
    do_step(4'd11, OP_WR, 12'h81C, 32'h9);  // line 5 is still high
    do_step(4'd11, OP_NOMSG, 12'h000, 32'h0);
    do_step(4'd11, OP_MSG, 12'h000, 32'd5);
    do_step(4'd11, OP_NOMSG, 12'h000, 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule